// File: doc/BRIEF.md
# Kernel Stack Limit Zone Checker

This block watches every kernel-mode write that goes through the stack pointer. It compares the address against a programmable limit and places the write in one of three zones. In the normal zone nothing happens. In the yellow zone, a warning band just above the limit, the write completes and a deferred trap request is recorded. That request is taken through vector 4 once the current instruction finishes. In the red zone, a band 040 (octal) bytes further down, the write is aborted in the same cycle. SP is then forced to 4 and a fatal stack-error vector flow begins.

The block also keeps the pending trap requests and dispatches them by priority when the sequencer reaches an instruction boundary. It tracks two flags. The yellow vector flag stops a second yellow request while the yellow trap is being vectored. The fatal flow flag turns off all stack checking while the fatal error is being vectored, and any further access error during that flow requests a halt. Both flags clear when the sequencer loads the new PC.

Top module: `stkz_guard`

## Requirements
- R1: With limit byte L, a checked write at address A is yellow when A[15:8] <= L. It is red when A + 040 (octal) <= {L, 8'hFF}. At L = 3, 0o1776 and 0o1740 are yellow but not red, 0o1736 is red and 0o2000 is normal. At L = 0, 0o376 is yellow.
- R2: A write is checked only when all of the following hold: acc_valid, acc_kernel and acc_write are 1, acc_console is 0, and acc_kind is one of three values. Those values are 2'b01 (implicit push), 2'b10 (vector push), or 2'b00 (explicit destination) with acc_sp = 1 and acc_dmode equal to 1, 2, 4 or 6. Reads, kind 2'b11, and modes 0, 3, 5 and 7 are never checked.
- R3: A checked red write raises acc_abort in the same cycle. In the next cycle sp_force = 1, sp_new = 4, err_rsv_set = 1 and f_flow = 1.
- R4: A checked yellow write is not aborted. From the next cycle on it leaves a yellow trap request pending, unless y_flow is set.
- R5: trap_pend is 1 when an MMU request or a yellow request is pending, or when trace_flag is 1. disp_vec picks the first of these that applies, in this order: MMU 0o250, yellow 0o004, trace 0o014. It is 0 when none applies. disp_go while trap_pend is 1 clears both pending requests at the clock edge.
- R6: A dispatch that selects the yellow request sets y_flow and pulses err_ysv_set in the next cycle. While y_flow is 1, yellow writes record no request.
- R7: pc_load clears y_flow and f_flow at the next edge.
- R8: While f_flow is 1, no write is checked, so there is no abort and no yellow request.
- R9: A valid access with acc_err = 1 while f_flow is 1 gives halt_req = 1 and halt_code = 4'b1001 in the next cycle. At all other times both are 0.
- R10: An access with acc_console = 1 records no MMU request and no stack violation.
- R11: A red abort cancels any pending MMU and yellow requests and clears y_flow.
- R12: After reset the limit byte is 0, nothing is pending, both flags are clear and all strobes are low. lim_we loads lim_din, which takes effect from the next cycle.
- R13: A new request raised in the same cycle as a dispatch stays pending after that dispatch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lim_we | input | 1 | Load the stack limit byte |
| lim_din | input | 8 | New stack limit byte |
| acc_valid | input | 1 | Memory access presented this cycle |
| acc_addr | input | 16 | Virtual address of the access |
| acc_kernel | input | 1 | Access is made in kernel mode |
| acc_write | input | 1 | Access is a write |
| acc_console | input | 1 | Access comes from the console |
| acc_sp | input | 1 | Destination register is SP |
| acc_kind | input | 2 | 00 destination, 01 implicit push, 10 vector push, 11 other |
| acc_dmode | input | 3 | Destination addressing mode |
| acc_err | input | 1 | Access ended in another abort |
| mmu_treq | input | 1 | MMU trap requested by this access |
| trace_flag | input | 1 | Trace bit of the status word |
| disp_go | input | 1 | Sequencer at trap dispatch point |
| pc_load | input | 1 | New PC loaded at end of vector flow |
| acc_abort | output | 1 | Abort the current write (red zone) |
| sp_force | output | 1 | Load SP with sp_new |
| sp_new | output | 16 | Value for SP (4 when forced) |
| err_rsv_set | output | 1 | Set red-violation bit of error register |
| err_ysv_set | output | 1 | Set yellow-violation bit of error register |
| trap_pend | output | 1 | A trap is waiting for dispatch |
| disp_vec | output | 9 | Vector of the highest pending trap |
| y_flow | output | 1 | Yellow trap vector flow active |
| f_flow | output | 1 | Fatal stack-error vector flow active |
| halt_req | output | 1 | Halt request, recursive fatal error |
| halt_code | output | 4 | Run status code for the halt |

## Verification
Addresses are placed at the zone edges for two limit values: 0o2000, 0o1776, 0o1740 and 0o1736 at limit 3, and 0o376, 0o340 and 0o336 at limit 0. These show whether the byte-wide yellow compare and the 040-byte red offset are both right. The same red address is then sent with each qualifier changed one at a time: read, each destination mode, implicit and vector pushes, user mode, another register, console source. This separates the zone compare from the gating. Trap requests are mixed (MMU with yellow, yellow alone, trace alone, and a yellow write arriving in the very cycle of a dispatch). These show the priority order, the full clear on dispatch and the rule that a new request is not lost. Red aborts while flows are active show the flow cancellation and the recursive halt.

// File: rtl/stkz_pkg.sv
`timescale 1ns/1ps
package stkz_pkg;
  localparam int VEC_W = 9;
  localparam logic [VEC_W-1:0] VEC_MMU = 9'o250;
  localparam logic [VEC_W-1:0] VEC_YEL = 9'o004;
  localparam logic [VEC_W-1:0] VEC_TRC = 9'o014;
  localparam logic [VEC_W-1:0] VEC_NONE = '0;
  localparam logic [3:0] HALT_RECUR = 4'b1001;

  localparam logic [1:0] KIND_DST  = 2'b00;
  localparam logic [1:0] KIND_IMPL = 2'b01;
  localparam logic [1:0] KIND_VEC  = 2'b10;

  typedef enum logic [1:0] {ZN_NONE = 2'd0, ZN_YEL = 2'd1, ZN_RED = 2'd2} zone_e;
endpackage

// File: rtl/stkz_zone.sv
`timescale 1ns/1ps
module stkz_zone
  import stkz_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 8,
  parameter int RED_GAP = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [LW-1:0] lim,
  output zone_e         zone
);
  localparam int LOW = AW - LW;

  // upper address byte at or below the limit byte
  function automatic logic hit_yellow(logic [AW-1:0] a, logic [LW-1:0] l);
    return a[AW-1 -: LW] <= l;
  endfunction

  // address plus the gap still fits under the top of the yellow band
  function automatic logic hit_red(logic [AW-1:0] a, logic [LW-1:0] l);
    logic [AW:0] ceil_v;
    logic [AW:0] probe;
    ceil_v = {1'b0, l, {LOW{1'b1}}};
    probe  = {1'b0, a} + (AW+1)'(RED_GAP);
    return probe <= ceil_v;
  endfunction

  always_comb begin
    if (hit_red(addr, lim))         zone = ZN_RED;
    else if (hit_yellow(addr, lim)) zone = ZN_YEL;
    else                            zone = ZN_NONE;
  end
endmodule

// File: rtl/stkz_qual.sv
`timescale 1ns/1ps
module stkz_qual
  import stkz_pkg::*;
(
  input  logic       valid,
  input  logic       kernel,
  input  logic       write,
  input  logic       console,
  input  logic       fatal_active,
  input  logic       via_sp,
  input  logic [1:0] kind,
  input  logic [2:0] dmode,
  output logic       checked
);
  // destination modes that write through the register before or at the address
  function automatic logic mode_checked(logic [2:0] m);
    case (m)
      3'd1, 3'd2, 3'd4, 3'd6: return 1'b1;
      default:                return 1'b0;
    endcase
  endfunction

  logic kind_ok;
  always_comb begin
    case (kind)
      KIND_DST:           kind_ok = via_sp & mode_checked(dmode);
      KIND_IMPL, KIND_VEC: kind_ok = 1'b1;
      default:            kind_ok = 1'b0;
    endcase
  end

  assign checked = valid & kernel & write & ~console & ~fatal_active & kind_ok;
endmodule

// File: rtl/stkz_trapq.sv
`timescale 1ns/1ps
module stkz_trapq
  import stkz_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             red_hit,
  input  logic             yel_req,
  input  logic             mmu_req,
  input  logic             trace,
  input  logic             disp_go,
  output logic             trap_pend,
  output logic [VEC_W-1:0] disp_vec,
  output logic             ysv_take
);
  logic mmu_p, yel_p;
  logic fire;

  function automatic logic [VEC_W-1:0] pick_vec(logic m, logic y, logic t);
    if (m)      return VEC_MMU;
    else if (y) return VEC_YEL;
    else if (t) return VEC_TRC;
    else        return VEC_NONE;
  endfunction

  assign trap_pend = mmu_p | yel_p | trace;
  assign disp_vec  = pick_vec(mmu_p, yel_p, trace);
  assign fire      = disp_go & trap_pend;
  assign ysv_take  = fire & ~mmu_p & yel_p;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mmu_p <= 1'b0;
      yel_p <= 1'b0;
    end else begin
      if (red_hit)      mmu_p <= 1'b0;
      else if (mmu_req) mmu_p <= 1'b1;
      else if (fire)    mmu_p <= 1'b0;

      if (red_hit)      yel_p <= 1'b0;
      else if (yel_req) yel_p <= 1'b1;
      else if (fire)    yel_p <= 1'b0;
    end
  end

  // R5
  mmu_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_go && trap_pend && !mmu_req |=> disp_vec != VEC_MMU);

  // R13
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_go && yel_req && !red_hit |=> trap_pend);
endmodule

// File: rtl/stkz_flow.sv
`timescale 1ns/1ps
module stkz_flow (
  input  logic clk,
  input  logic rst_n,
  input  logic red_hit,
  input  logic ysv_take,
  input  logic pc_load,
  input  logic err_hit,
  output logic y_flow,
  output logic f_flow,
  output logic red_q,
  output logic ysv_q,
  output logic halt_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y_flow <= 1'b0;
      f_flow <= 1'b0;
      red_q  <= 1'b0;
      ysv_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      red_q  <= red_hit;
      ysv_q  <= ysv_take;
      halt_q <= err_hit & f_flow;

      if (red_hit)       y_flow <= 1'b0;
      else if (ysv_take) y_flow <= 1'b1;
      else if (pc_load)  y_flow <= 1'b0;

      if (red_hit)      f_flow <= 1'b1;
      else if (pc_load) f_flow <= 1'b0;
    end
  end

  // R6
  ysv_flow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ysv_take && !red_hit |=> y_flow && ysv_q);

  // R7
  pc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load && !red_hit && !ysv_take |=> !y_flow && !f_flow);

  // R9
  halt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halt_q |-> $past(f_flow));
endmodule

// File: rtl/stkz_guard.sv
`timescale 1ns/1ps
module stkz_guard
  import stkz_pkg::*;
#(
  parameter int AW = 16,
  parameter int LW = 8,
  parameter int RED_GAP = 32,
  parameter int SP_FORCE_VAL = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lim_we,
  input  logic [LW-1:0]    lim_din,
  input  logic             acc_valid,
  input  logic [AW-1:0]    acc_addr,
  input  logic             acc_kernel,
  input  logic             acc_write,
  input  logic             acc_console,
  input  logic             acc_sp,
  input  logic [1:0]       acc_kind,
  input  logic [2:0]       acc_dmode,
  input  logic             acc_err,
  input  logic             mmu_treq,
  input  logic             trace_flag,
  input  logic             disp_go,
  input  logic             pc_load,
  output logic             acc_abort,
  output logic             sp_force,
  output logic [AW-1:0]    sp_new,
  output logic             err_rsv_set,
  output logic             err_ysv_set,
  output logic             trap_pend,
  output logic [VEC_W-1:0] disp_vec,
  output logic             y_flow,
  output logic             f_flow,
  output logic             halt_req,
  output logic [3:0]       halt_code
);
  localparam logic [AW-1:0] SP_VAL = AW'(SP_FORCE_VAL);

  logic [LW-1:0] lim_q;
  zone_e         zone;
  logic          checked;
  logic          red_hit, yel_req, mmu_req, err_hit, ysv_take;
  logic          red_q, ysv_q, halt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      lim_q <= '0;
    else if (lim_we) lim_q <= lim_din;
  end

  stkz_zone #(.AW(AW), .LW(LW), .RED_GAP(RED_GAP)) u_zone (
    .addr(acc_addr), .lim(lim_q), .zone(zone)
  );

  stkz_qual u_qual (
    .valid(acc_valid), .kernel(acc_kernel), .write(acc_write),
    .console(acc_console), .fatal_active(f_flow), .via_sp(acc_sp),
    .kind(acc_kind), .dmode(acc_dmode), .checked(checked)
  );

  assign red_hit = checked & (zone == ZN_RED);
  assign yel_req = checked & (zone == ZN_YEL) & ~y_flow;
  assign mmu_req = acc_valid & mmu_treq & ~acc_console;
  assign err_hit = acc_valid & acc_err;

  stkz_trapq u_trapq (
    .clk(clk), .rst_n(rst_n), .red_hit(red_hit), .yel_req(yel_req),
    .mmu_req(mmu_req), .trace(trace_flag), .disp_go(disp_go),
    .trap_pend(trap_pend), .disp_vec(disp_vec), .ysv_take(ysv_take)
  );

  stkz_flow u_flow (
    .clk(clk), .rst_n(rst_n), .red_hit(red_hit), .ysv_take(ysv_take),
    .pc_load(pc_load), .err_hit(err_hit), .y_flow(y_flow), .f_flow(f_flow),
    .red_q(red_q), .ysv_q(ysv_q), .halt_q(halt_q)
  );

  assign acc_abort   = red_hit;
  assign sp_force    = red_q;
  assign sp_new      = red_q ? SP_VAL : '0;
  assign err_rsv_set = red_q;
  assign err_ysv_set = ysv_q;
  assign halt_req    = halt_q;
  assign halt_code   = halt_q ? HALT_RECUR : 4'b0000;

  // R3
  red_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_abort |=> sp_force && f_flow && err_rsv_set && sp_new == SP_VAL);

  // R8
  fatal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    f_flow |-> !acc_abort);

  // R2
  read_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid && !acc_write |-> !acc_abort);

  // R11
  red_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_abort |=> !y_flow);
endmodule

// File: tb/sim_stkz_guard.sv
`timescale 1ns/1ps
module sim_stkz_guard;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lim_we = 0, acc_valid = 0, acc_kernel = 0, acc_write = 0, acc_console = 0;
  logic acc_sp = 0, acc_err = 0, mmu_treq = 0, trace_flag = 0, disp_go = 0, pc_load = 0;
  logic [7:0]  lim_din = '0;
  logic [15:0] acc_addr = '0;
  logic [1:0]  acc_kind = '0;
  logic [2:0]  acc_dmode = '0;
  logic acc_abort, sp_force, err_rsv_set, err_ysv_set, trap_pend, y_flow, f_flow, halt_req;
  logic [15:0] sp_new;
  logic [8:0]  disp_vec;
  logic [3:0]  halt_code;

  always #5 clk = ~clk;

  stkz_guard u0 (
    .clk(clk), .rst_n(rst_n), .lim_we(lim_we), .lim_din(lim_din),
    .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_kernel(acc_kernel),
    .acc_write(acc_write), .acc_console(acc_console), .acc_sp(acc_sp),
    .acc_kind(acc_kind), .acc_dmode(acc_dmode), .acc_err(acc_err),
    .mmu_treq(mmu_treq), .trace_flag(trace_flag), .disp_go(disp_go),
    .pc_load(pc_load), .acc_abort(acc_abort), .sp_force(sp_force),
    .sp_new(sp_new), .err_rsv_set(err_rsv_set), .err_ysv_set(err_ysv_set),
    .trap_pend(trap_pend), .disp_vec(disp_vec), .y_flow(y_flow),
    .f_flow(f_flow), .halt_req(halt_req), .halt_code(halt_code)
  );

  typedef struct {
    logic v, kern, wr, con, sp, err, mmu, trc, disp, pcl, lwe;
    logic [1:0] kind; logic [2:0] dm; logic [15:0] addr; logic [7:0] ldin;
  } stim_t;
  typedef struct { int due; int sel; int val; string req; } exp_t;

  exp_t sbq[$];
  int cyc = 0, checks = 0, errors = 0;
  bit finished = 0;
  int m_lim = 0;
  bit m_mp = 0, m_yp = 0, m_yf = 0, m_ff = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int obs(int sel);
    case (sel)
      0: return int'(acc_abort);   1: return int'(trap_pend);
      2: return int'(disp_vec);    3: return int'(sp_force);
      4: return int'(sp_new);      5: return int'(err_rsv_set);
      6: return int'(err_ysv_set); 7: return int'(halt_req);
      8: return int'(halt_code);   9: return int'(y_flow);
      default: return int'(f_flow);
    endcase
  endfunction

  function automatic string sname(int sel);
    case (sel)
      0: return "acc_abort";   1: return "trap_pend";  2: return "disp_vec";
      3: return "sp_force";    4: return "sp_new";     5: return "err_rsv_set";
      6: return "err_ysv_set"; 7: return "halt_req";   8: return "halt_code";
      9: return "y_flow";      default: return "f_flow";
    endcase
  endfunction

  // monitor: pop due expectations and compare away from the active edge
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cyc) begin
      exp_t e;
      int got;
      e = sbq.pop_front();
      got = obs(e.sel);
      checks++;
      if (got != e.val) begin
        errors++;
        $display("FAIL %s %s actual %0d expected %0d (cycle %0d)",
                 e.req, sname(e.sel), got, e.val, cyc);
      end
    end
  end

  task automatic push(int due, int sel, int val, string req);
    exp_t e;
    e.due = due; e.sel = sel; e.val = val; e.req = req;
    sbq.push_back(e);
  endtask

  function automatic stim_t idle();
    stim_t s;
    s = '{default: '0};
    return s;
  endfunction

  function automatic stim_t kw(logic [1:0] kind, logic [2:0] dm, logic [15:0] addr);
    stim_t s;
    s = idle();
    s.v = 1; s.kern = 1; s.wr = 1; s.sp = 1;
    s.kind = kind; s.dm = dm; s.addr = addr;
    return s;
  endfunction

  // driver: apply one cycle of stimulus and queue what the requirements predict
  task automatic step(string req, stim_t s);
    bit kok, chk, red, yel, pend, fire, ytake, halt;
    int vec, a, band;
    @(posedge clk); #1;
    acc_valid = s.v; acc_kernel = s.kern; acc_write = s.wr; acc_console = s.con;
    acc_sp = s.sp; acc_kind = s.kind; acc_dmode = s.dm; acc_addr = s.addr;
    acc_err = s.err; mmu_treq = s.mmu; trace_flag = s.trc; disp_go = s.disp;
    pc_load = s.pcl; lim_we = s.lwe; lim_din = s.ldin;

    kok  = (s.kind == 2'b01) || (s.kind == 2'b10) ||
           (s.kind == 2'b00 && s.sp && (s.dm == 1 || s.dm == 2 || s.dm == 4 || s.dm == 6));
    chk  = s.v && s.kern && s.wr && !s.con && !m_ff && kok;
    a    = int'(s.addr);
    band = (m_lim + 1) * 256;
    red  = chk && (a + 32 < band);
    yel  = chk && !red && (a < band);
    pend = m_mp || m_yp || s.trc;
    vec  = m_mp ? 168 : (m_yp ? 4 : (s.trc ? 12 : 0));
    fire = s.disp && pend;
    ytake = fire && !m_mp && m_yp;
    halt = s.v && s.err && m_ff;

    push(cyc, 0, int'(red), req);
    push(cyc, 1, int'(pend), req);
    push(cyc, 2, vec, req);

    if (red) begin m_mp = 0; m_yp = 0; m_yf = 0; m_ff = 1; end
    else begin
      if (s.v && s.mmu && !s.con) m_mp = 1; else if (fire) m_mp = 0;
      if (yel && !m_yf) m_yp = 1; else if (fire) m_yp = 0;
      if (ytake) m_yf = 1; else if (s.pcl) m_yf = 0;
      if (s.pcl) m_ff = 0;
    end
    if (s.lwe) m_lim = int'(s.ldin);

    push(cyc + 1, 3, int'(red), req);
    push(cyc + 1, 4, red ? 4 : 0, req);
    push(cyc + 1, 5, int'(red), req);
    push(cyc + 1, 6, int'(ytake), req);
    push(cyc + 1, 7, int'(halt), req);
    push(cyc + 1, 8, halt ? 9 : 0, req);
    push(cyc + 1, 9, int'(m_yf), req);
    push(cyc + 1, 10, int'(m_ff), req);
  endtask

  task automatic drain(string req);
    stim_t s;
    s = idle(); s.disp = 1; step(req, s);
    s = idle(); s.pcl = 1;  step(req, s);
  endtask

  initial begin
    stim_t s;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state, default limit 0
    step("R12", idle());

    // default limit: 0o376 yellow, 0o400 normal, 0o340 yellow only, 0o336 red
    step("R1", kw(2'b00, 3'd4, 16'o376));
    step("R4", idle());
    s = idle(); s.disp = 1; step("R6", s);
    step("R6", kw(2'b00, 3'd4, 16'o370));
    step("R6", idle());
    s = idle(); s.pcl = 1; step("R7", s);
    step("R1", kw(2'b00, 3'd4, 16'o400));
    step("R1", kw(2'b00, 3'd4, 16'o340));
    drain("R1");
    step("R1", kw(2'b00, 3'd4, 16'o336));
    s = idle(); s.pcl = 1; step("R7", s);

    // limit 3 (0o1400)
    s = idle(); s.lwe = 1; s.ldin = 8'h03; step("R12", s);
    step("R1", kw(2'b00, 3'd4, 16'o2000));
    step("R1", kw(2'b00, 3'd2, 16'o1776));
    drain("R1");
    step("R1", kw(2'b00, 3'd6, 16'o1740));
    drain("R1");
    step("R3", kw(2'b00, 3'd1, 16'o1736));
    step("R8", kw(2'b00, 3'd4, 16'o1700));
    s = idle(); s.v = 1; s.err = 1; step("R9", s);
    s = idle(); s.pcl = 1; step("R7", s);
    s = idle(); s.v = 1; s.err = 1; step("R9", s);

    // qualifiers on a red address
    s = kw(2'b00, 3'd4, 16'o1700); s.wr = 0; step("R2", s);
    for (int m = 0; m < 8; m++) begin
      if (m == 0 || m == 3 || m == 5 || m == 7) step("R2", kw(2'b00, 3'(m), 16'o1700));
    end
    s = kw(2'b00, 3'd4, 16'o1700); s.kern = 0; step("R2", s);
    s = kw(2'b00, 3'd4, 16'o1700); s.sp = 0; step("R2", s);
    step("R2", kw(2'b11, 3'd4, 16'o1700));
    step("R2", kw(2'b01, 3'd0, 16'o1700));
    s = idle(); s.pcl = 1; step("R7", s);
    step("R2", kw(2'b10, 3'd0, 16'o1700));
    s = idle(); s.pcl = 1; step("R7", s);

    // console accesses
    s = kw(2'b00, 3'd4, 16'o1700); s.con = 1; step("R10", s);
    s = idle(); s.v = 1; s.mmu = 1; s.con = 1; step("R10", s);
    step("R10", idle());

    // priority
    s = kw(2'b00, 3'd4, 16'o1776); s.mmu = 1; step("R5", s);
    s = idle(); s.trc = 1; s.disp = 1; step("R5", s);
    s = idle(); s.trc = 1; step("R5", s);
    s = idle(); s.trc = 1; s.disp = 1; step("R5", s);
    step("R5", idle());

    // red entry cancels requests and yellow flow
    step("R11", kw(2'b00, 3'd4, 16'o1776));
    s = idle(); s.disp = 1; step("R11", s);
    s = kw(2'b00, 3'd4, 16'o1776); s.mmu = 1; step("R11", s);
    step("R11", kw(2'b00, 3'd4, 16'o1700));
    step("R11", idle());
    s = idle(); s.pcl = 1; step("R7", s);

    // request raised in the dispatch cycle
    step("R13", kw(2'b00, 3'd4, 16'o1776));
    s = kw(2'b00, 3'd4, 16'o1770); s.disp = 1; step("R13", s);
    step("R13", idle());
    drain("R13");

    step("R12", idle());
    step("R12", idle());
    repeat (2) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc == 20000 && !finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule